// File: doc/BRIEF.md
# Host-Driven Bus Cycle Bridge

A host processor with only a narrow parallel port uses this block to run 16-bit cycles on a 68000-style bus. The port has a 16-bit bidirectional data path, a 2-bit register select, and active-high write and read strobes. The host loads up to three 16-bit registers. Writing the address-high register starts the cycle. That register carries the top address bits and a 2-bit command, so word and byte reads and writes all go through the same short sequence.

The write strobe is asynchronous to the block clock and is synchronised through a flop chain. A register is captured on the rising edge of the synchronised strobe. The block then raises a request toward a generic bus target. The request carries the 24-bit address, a write enable, the upper and lower byte-lane strobes and the write data.

Flow control works in two places:

- **Target side:** the target applies back-pressure by holding off its one-cycle acknowledge. Every request field stays frozen until that acknowledge arrives.
- **Host side:** the host applies back-pressure through the busy flag, which it polls before reading a result or starting another access.

Read data returned with the acknowledge goes into the data register. The host fetches it by selecting that register and raising the read strobe. The port drivers are enabled only during that combination.

Top module: `hbb_top`

## Requirements
- R1: After reset the busy flag and the request are low and the data and address-low registers read as zero.
- R2: Register select 0 addresses the data register, 1 the address-low register (address bits 15:0) and 2 the address-high register. A write with select 3 changes no register and starts nothing.
- R3: In the address-high word, bits 7:0 give address bits 23:16 and bits 9:8 give the command: 0 word write, 1 byte write, 2 word read, 3 byte read. Writing this register launches the cycle, with the write enable high for commands 0 and 1.
- R4: Busy and the request rise together at launch and stay high until the cycle in which the target acknowledges. They are low in the cycle after that. Address, write enable, strobes and write data hold steady while the request waits.
- R5: A word access asserts both the upper and lower strobes.
- R6: A byte access at an even address (bit 0 = 0) asserts only the upper strobe. A byte access at an odd address asserts only the lower strobe.
- R7: The write data presented to the target is the full 16-bit data-register value. An even byte write therefore passes the duplicated byte on both halves while still asserting only the upper strobe.
- R8: For word and byte reads alike, the full 16-bit word returned with the acknowledge is loaded into the data register and appears on the port when the host reads it.
- R9: A write to address-high while busy is ignored: the cycle in flight is untouched and no second cycle follows.
- R10: The block drives the port data only while the read strobe is high and select is 0. At all other times its drivers are off.
- R11: Writes to the data or address-low register while busy do not alter the request in flight.
- R12: When a read acknowledge and a host write to the data register land in the same clock cycle, the read result is what the data register keeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select from the host |
| host_wr | input | 1 | Host write strobe, active high, asynchronous |
| host_rd | input | 1 | Host read strobe, active high |
| host_data | inout | 16 | Bidirectional host data path |
| host_busy | output | 1 | Cycle in progress |
| tgt_req | output | 1 | Request toward the bus target |
| tgt_addr | output | 24 | Bus address |
| tgt_we | output | 1 | 1 for write cycles |
| tgt_uds | output | 1 | Upper byte-lane strobe |
| tgt_lds | output | 1 | Lower byte-lane strobe |
| tgt_wdata | output | 16 | Write data |
| tgt_ack | input | 1 | One-cycle acknowledge from the target |
| tgt_rdata | input | 16 | Read data, valid with the acknowledge |

## Verification
Two updates can hit the data register in the same clock edge:

- the load of a read result when the target acknowledges;
- a host write arriving through the strobe synchroniser.

The bench provokes this by raising the host write strobe exactly two clock edges before it drives the acknowledge. With that timing, the synchronised strobe edge and the acknowledge are sampled on the same clock edge. The outcome is judged by reading the data register through the port afterwards, where the acknowledged word must appear rather than the host's value.

A second overlap is a host address-high write while a cycle is outstanding. The bench judges it by watching the target side: the request fields must not move, and no new request may appear after the acknowledge.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
  localparam int unsigned HBB_DW = 16;
  localparam int unsigned HBB_AW = 24;

  typedef enum logic [1:0] {
    CMD_WR_WORD = 2'd0,
    CMD_WR_BYTE = 2'd1,
    CMD_RD_WORD = 2'd2,
    CMD_RD_BYTE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    SEL_DATA    = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_ADDR_HI = 2'd2,
    SEL_SPARE   = 2'd3
  } sel_e;
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned NST = (STAGES < 2) ? 2 : STAGES;

  logic [NST-1:0] chain;
  logic           last_q;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[NST-1];
  end

  assign rise = chain[NST-1] & ~last_q;

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/hbb_regs.sv
module hbb_regs
  import hbb_pkg::*;
#(
  parameter int unsigned DW = HBB_DW,
  parameter int unsigned AW = HBB_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_pulse,
  input  sel_e          sel,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          ld_rd,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] data_q,
  output logic          launch,
  output logic [AW-1:0] launch_addr,
  output cmd_e          launch_cmd
);
  localparam int unsigned HI_BITS = AW - DW;
  localparam int unsigned CMD_LSB = HI_BITS;

  logic [DW-1:0] addr_lo_q;
  logic          hit_data, hit_lo, hit_hi;

  always_comb begin
    hit_data = wr_pulse && (sel == SEL_DATA);
    hit_lo   = wr_pulse && (sel == SEL_ADDR_LO);
    hit_hi   = wr_pulse && (sel == SEL_ADDR_HI);
  end

  // read result has priority over a coincident host write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (ld_rd)    data_q <= rd_word;
    else if (hit_data) data_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_lo_q <= '0;
    else if (hit_lo) addr_lo_q <= wdata;
  end

  assign launch      = hit_hi && !busy;
  assign launch_addr = {wdata[HI_BITS-1:0], addr_lo_q};
  assign launch_cmd  = cmd_e'(wdata[CMD_LSB+1:CMD_LSB]);

  a_r12_result_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rd |=> data_q == $past(rd_word));
  a_r2_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && sel == SEL_SPARE && !ld_rd) |=> ($stable(data_q) && $stable(addr_lo_q)));
  a_r9_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
endmodule

// File: rtl/hbb_engine.sv
module hbb_engine
  import hbb_pkg::*;
#(
  parameter int unsigned DW = HBB_DW,
  parameter int unsigned AW = HBB_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] launch_addr,
  input  cmd_e          launch_cmd,
  input  logic [DW-1:0] launch_wdata,
  output logic          busy,
  output logic          tgt_req,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_we,
  output logic          tgt_uds,
  output logic          tgt_lds,
  output logic [DW-1:0] tgt_wdata,
  input  logic          tgt_ack,
  input  logic [DW-1:0] tgt_rdata,
  output logic          ld_rd,
  output logic [DW-1:0] rd_word
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e           st_q;
  logic [AW-1:0] addr_q;
  cmd_e          cmd_q;
  logic [DW-1:0] wd_q;
  logic          is_byte, is_read, waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      cmd_q  <= CMD_WR_WORD;
      wd_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q   <= ST_WAIT;
          addr_q <= launch_addr;
          cmd_q  <= launch_cmd;
          wd_q   <= launch_wdata;
        end
        ST_WAIT: if (tgt_ack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    waiting   = (st_q == ST_WAIT);
    is_byte   = cmd_q[0];
    is_read   = cmd_q[1];
    busy      = waiting;
    tgt_req   = waiting;
    tgt_addr  = addr_q;
    tgt_we    = waiting && !is_read;
    tgt_uds   = waiting && (!is_byte || !addr_q[0]);
    tgt_lds   = waiting && (!is_byte ||  addr_q[0]);
    tgt_wdata = wd_q;
    ld_rd     = waiting && tgt_ack && is_read;
    rd_word   = tgt_rdata;
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_we)
      && $stable(tgt_wdata) && $stable(tgt_uds) && $stable(tgt_lds)));
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && tgt_ack) |=> !tgt_req);
  a_r6_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && is_byte) |-> $countones({tgt_uds, tgt_lds}) == 1);
  a_r5_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !is_byte) |-> (tgt_uds && tgt_lds));
  a_r3_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> tgt_req);
endmodule

// File: rtl/hbb_top.sv
module hbb_top
  import hbb_pkg::*;
#(
  parameter int unsigned DW          = HBB_DW,
  parameter int unsigned AW          = HBB_AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  inout  wire  [DW-1:0] host_data,
  output logic          host_busy,
  output logic          tgt_req,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_we,
  output logic          tgt_uds,
  output logic          tgt_lds,
  output logic [DW-1:0] tgt_wdata,
  input  logic          tgt_ack,
  input  logic [DW-1:0] tgt_rdata
);
  logic          wr_rise, launch, ld_rd, busy;
  logic [DW-1:0] data_q, rd_word;
  logic [AW-1:0] launch_addr;
  cmd_e          launch_cmd;
  sel_e          sel;
  logic          port_oe;

  assign sel = sel_e'(host_sel);

  hbb_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .async_in(host_wr), .rise(wr_rise)
  );

  hbb_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_rise), .sel(sel),
    .wdata(host_data), .busy(busy), .ld_rd(ld_rd), .rd_word(rd_word),
    .data_q(data_q), .launch(launch), .launch_addr(launch_addr),
    .launch_cmd(launch_cmd)
  );

  hbb_engine #(.DW(DW), .AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_addr(launch_addr),
    .launch_cmd(launch_cmd), .launch_wdata(data_q), .busy(busy),
    .tgt_req(tgt_req), .tgt_addr(tgt_addr), .tgt_we(tgt_we),
    .tgt_uds(tgt_uds), .tgt_lds(tgt_lds), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata), .ld_rd(ld_rd), .rd_word(rd_word)
  );

  assign port_oe   = host_rd && (sel == SEL_DATA);
  assign host_data = port_oe ? data_q : 'z;
  assign host_busy = busy;

  a_r4_busy_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> host_busy);
endmodule

// File: tb/tb_hbb_top.sv
module tb_hbb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  wire  [15:0] host_data;
  logic        drv_en = 1'b0;
  logic [15:0] drv_val = 16'h0;
  logic        host_busy, tgt_req, tgt_we, tgt_uds, tgt_lds;
  logic [23:0] tgt_addr;
  logic [15:0] tgt_wdata;
  logic        tgt_ack = 1'b0;
  logic [15:0] tgt_rdata = 16'h0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign host_data = drv_en ? drv_val : 'z;

  hbb_top dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_data(host_data), .host_busy(host_busy),
    .tgt_req(tgt_req), .tgt_addr(tgt_addr), .tgt_we(tgt_we),
    .tgt_uds(tgt_uds), .tgt_lds(tgt_lds), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_pat(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h3C5A;
  endfunction

  task automatic host_write(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    host_sel = s; drv_val = v; drv_en = 1'b1; host_wr = 1'b1;
    repeat (3) @(negedge clk);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
    drv_en = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    host_sel = s; host_rd = 1'b1;
    #1 v = host_data;
    host_rd = 1'b0;
  endtask

  task automatic ack_now(input logic [15:0] rv);
    tgt_ack = 1'b1; tgt_rdata = rv;
    @(negedge clk);
    tgt_ack = 1'b0;
  endtask

  task automatic run_cycle(input logic [1:0] cmd, input logic [23:0] a, input logic [15:0] d, input int lat);
    logic [15:0] rv;
    bit is_byte, is_read;
    is_byte = cmd[0]; is_read = cmd[1];
    if (!is_read) host_write(2'd0, d);
    host_write(2'd1, a[15:0]);
    host_write(2'd2, {6'd0, cmd, a[23:16]});
    chk(tgt_req && host_busy, "R4 req/busy raised", {tgt_req, host_busy}, 2'b11);
    chk(tgt_addr == a, "R3 address", tgt_addr, a);
    chk(tgt_we == !is_read, "R3 write enable", tgt_we, !is_read);
    if (!is_byte)
      chk(tgt_uds && tgt_lds, "R5 word lanes", {tgt_uds, tgt_lds}, 2'b11);
    else
      chk({tgt_uds, tgt_lds} == (a[0] ? 2'b01 : 2'b10), "R6 byte lane",
          {tgt_uds, tgt_lds}, a[0] ? 2'b01 : 2'b10);
    if (!is_read) chk(tgt_wdata == d, "R7 write data", tgt_wdata, d);
    for (int k = 0; k < lat; k++) @(negedge clk);
    chk(tgt_req && tgt_addr == a, "R4 held while waiting", tgt_addr, a);
    ack_now(rd_pat(a));
    chk(!tgt_req && !host_busy, "R4 released after ack", {tgt_req, host_busy}, 2'b00);
    if (is_read) begin
      host_read(2'd0, rv);
      chk(rv == rd_pat(a), "R8 read word", rv, rd_pat(a));
    end
  endtask

  initial begin
    logic [15:0] v, b;
    logic [23:0] a;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk(!host_busy && !tgt_req, "R1 reset busy/req", {host_busy, tgt_req}, 2'b00);
    host_read(2'd0, v);
    chk(v == 16'h0, "R1 reset data reg", v, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: select 3 leaves registers alone
    host_write(2'd0, 16'h1234);
    host_write(2'd1, 16'h0ABC);
    host_write(2'd3, 16'hFFFF);
    chk(!tgt_req, "R2 spare starts nothing", tgt_req, 0);
    host_read(2'd0, v);
    chk(v == 16'h1234, "R2 spare keeps data", v, 16'h1234);
    host_write(2'd2, 16'h0055);
    chk(tgt_addr == 24'h550ABC, "R2 spare keeps addr-lo", tgt_addr, 24'h550ABC);
    ack_now(16'h0);

    // sweep of commands, address parity and target latency
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 2; p++)
        for (int l = 0; l < 4; l++) begin
          a = {8'(8'h40 + c*8 + l), 16'((16'h1200 + l*16'h0104 + c*16'h0030) & 16'hFFFE)} | 24'(p);
          b = 8'(8'hA1 + c*16 + l);
          if (c == 0)      d = 16'(16'h9000 + c*16'h111 + l*16'h0203 + p);
          else if (p == 0) d = {b[7:0], b[7:0]};
          else             d = {8'h00, b[7:0]};
          run_cycle(2'(c), a, d, l);
        end

    // R9 + R11: writes while busy leave the cycle alone
    run_one_busy();

    // R12: read acknowledge coincides with host data write
    host_write(2'd1, 16'h4446);
    host_write(2'd2, {6'd0, 2'd2, 8'h33});
    @(negedge clk);
    host_sel = 2'd0; drv_val = 16'hBEEF; drv_en = 1'b1; host_wr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tgt_ack = 1'b1; tgt_rdata = 16'hC0DE;
    @(negedge clk);
    tgt_ack = 1'b0; host_wr = 1'b0;
    repeat (3) @(negedge clk);
    drv_en = 1'b0;
    host_read(2'd0, v);
    chk(v == 16'hC0DE, "R12 read result wins", v, 16'hC0DE);

    // R10: drivers only on read with select 0
    host_write(2'd0, 16'h5A3C);
    host_read(2'd0, v);
    chk(v == 16'h5A3C, "R10 driven on data read", v, 16'h5A3C);
    host_read(2'd1, v);
    chk(v !== 16'h5A3C, "R10 off for other select", v, 16'h5A3C);
    @(negedge clk);
    host_sel = 2'd0;
    #1 chk(host_data !== 16'h5A3C, "R10 off without read strobe", host_data, 16'h5A3C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic run_one_busy();
    host_write(2'd0, 16'h6161);
    host_write(2'd1, 16'h2222);
    host_write(2'd2, {6'd0, 2'd0, 8'h11});
    host_write(2'd0, 16'h7777);
    host_write(2'd1, 16'h0000);
    chk(tgt_wdata == 16'h6161 && tgt_addr == 24'h112222, "R11 busy writes ignored", tgt_addr, 24'h112222);
    host_write(2'd2, {6'd0, 2'd2, 8'h99});
    chk(tgt_we && tgt_addr == 24'h112222, "R9 addr-hi while busy ignored", tgt_addr, 24'h112222);
    ack_now(16'h0);
    repeat (8) @(negedge clk);
    chk(!tgt_req && !host_busy, "R9 no second cycle", {tgt_req, host_busy}, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule